// File: doc/BRIEF.md
# Over-Current Alarm Throttle Controller

This block monitors a single over-current alarm line coming from outside the chip. It decides when to signal software and when to ask the clocking logic to slow down. The alarm is brought into the clock domain through a short synchronizer. Its active level is then normalized by a polarity setting. Each new assertion counts as one event.

When enough events accumulate, a one-cycle interrupt pulse is produced. If the alarm stays quiet for long enough, the event tally is forgotten. The throttle request follows the alarm and can be stretched by a programmable number of microseconds after the alarm clears.

All settings are loaded together through one write strobe. Each load starts the block from clean counting and timing state.

Top module: `oca_throttle`

## Requirements
- R1: After reset, irq_pulse and throttle_req are 0 and the settings are: polarity 0 (active-high), interrupt disabled, count limit 0, quiet length 0, hold time 0.
- R2: With polarity setting 0 the alarm is active when alarm_in is 1. With polarity setting 1 it is active when alarm_in is 0.
- R3: alarm_in passes through a two-flop synchronizer, and one event is counted on each inactive-to-active change. A change of alarm_in before clock edge k shows up at throttle_req and irq_pulse after edge k+2.
- R4: With a count limit N of 1 or more, the N-th counted event produces a single-cycle irq_pulse and returns the tally to zero, so the next N events fire again.
- R5: A count limit of 0 produces an interrupt pulse on every event.
- R6: While the interrupt enable setting is 0, irq_pulse is never asserted, whatever the events.
- R7: With quiet length L greater than 0, the tally is cleared once L clock cycles pass with no event, and each event restarts that window. With L equal to 0 the tally is never cleared by time.
- R8: throttle_req is 1 for as long as the synchronized alarm is active.
- R9: After the alarm deasserts, throttle_req stays 1 for H times US_DIV clock cycles, where H is the hold setting in microseconds. With H equal to 0 it drops in the same cycle relationship in which it rose.
- R10: A new alarm during the hold period cancels the countdown. The full hold restarts when the alarm next deasserts.
- R11: A configuration write (cfg_we high for one cycle) loads all settings and clears the event tally, the quiet timer, the hold timer and the microsecond prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_in | input | 1 | Asynchronous over-current alarm |
| cfg_we | input | 1 | Loads all settings; clears counting and timing state |
| cfg_inv_pol | input | 1 | Polarity: 1 means active-low |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_count_limit | input | CNT_W | Events needed per interrupt (0 means every event) |
| cfg_quiet_len | input | QUIET_W | Quiet window in clock cycles (0 means off) |
| cfg_hold_us | input | HOLD_W | Throttle hold after deassert, in microseconds |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| throttle_req | output | 1 | Throttle request |

## Verification
The checker assumes that settings change only through cfg_we pulses. It also assumes alarm_in holds each level for at least two clock cycles, so the synchronizer never drops an edge. The bench drives alarm_in and the settings only on falling clock edges and keeps every alarm phase at three cycles or more. It writes a new polarity only while the line sits where it produces no spurious event, or while the test is not checking the interrupt count.

// File: rtl/oca_pkg.sv
package oca_pkg;
  typedef struct packed {
    logic act;
    logic rise;
    logic fall;
  } oca_edge_t;
endpackage

// File: rtl/oca_alarm_front.sv
module oca_alarm_front
  import oca_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      alarm_in,
  input  logic      inv_pol,
  input  logic      cfg_we,
  input  logic      inv_pol_next,
  output oca_edge_t edg
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         act_d;
  logic         act;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[MSB-1:0], alarm_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= alarm_in;
      end
    end
  endgenerate

  assign act = sync_q[MSB] ^ inv_pol;

  // on a settings load, align the history with the new polarity so no
  // phantom edge appears
  always_ff @(posedge clk) begin
    if (rst)         act_d <= 1'b0;
    else if (cfg_we) act_d <= sync_q[MSB] ^ inv_pol_next;
    else             act_d <= act;
  end

  assign edg.act  = act;
  assign edg.rise = act & ~act_d;
  assign edg.fall = ~act & act_d;
endmodule

// File: rtl/oca_event_counter.sv
module oca_event_counter #(
  parameter int CNT_W   = 8,
  parameter int QUIET_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               rise,
  input  logic               irq_en,
  input  logic [CNT_W-1:0]   limit,
  input  logic [QUIET_W-1:0] quiet_len,
  output logic [CNT_W-1:0]   count_q,
  output logic               irq_q
);
  logic [QUIET_W-1:0] quiet_left;
  logic [CNT_W:0]     next_cnt;

  assign next_cnt = {1'b0, count_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q    <= '0;
      quiet_left <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (rise) begin
        quiet_left <= quiet_len;
        if (next_cnt >= {1'b0, limit}) begin
          count_q <= '0;
          irq_q   <= irq_en;
        end else begin
          count_q <= next_cnt[CNT_W-1:0];
        end
      end else if (quiet_len != '0) begin
        if (quiet_left <= QUIET_W'(1)) begin
          count_q    <= '0;
          quiet_left <= quiet_len;
        end else begin
          quiet_left <= quiet_left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/oca_hold_stretch.sv
module oca_hold_stretch #(
  parameter int HOLD_W = 16,
  parameter int US_DIV = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              act,
  input  logic              fall,
  input  logic [HOLD_W-1:0] hold_us,
  output logic [HOLD_W-1:0] hold_left,
  output logic              throttle_q
);
  localparam int DIV_W = (US_DIV > 1) ? $clog2(US_DIV) : 1;

  logic              tick;
  logic [HOLD_W-1:0] hold_next;

  generate
    if (US_DIV > 1) begin : g_presc
      logic [DIV_W-1:0] pre_q;
      assign tick = (pre_q == DIV_W'(US_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || clr || act || fall) pre_q <= '0;
        else if (tick)                 pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopresc
      assign tick = 1'b1;
    end
  endgenerate

  always_comb begin
    if (clr || act)                      hold_next = '0;
    else if (fall)                       hold_next = hold_us;
    else if (hold_left != '0 && tick)    hold_next = hold_left - 1'b1;
    else                                 hold_next = hold_left;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_left  <= '0;
      throttle_q <= 1'b0;
    end else begin
      hold_left  <= hold_next;
      throttle_q <= act | (hold_next != '0);
    end
  end
endmodule

// File: rtl/oca_throttle.sv
module oca_throttle
  import oca_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int QUIET_W = 24,
  parameter int HOLD_W  = 16,
  parameter int US_DIV  = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alarm_in,
  input  logic               cfg_we,
  input  logic               cfg_inv_pol,
  input  logic               cfg_irq_en,
  input  logic [CNT_W-1:0]   cfg_count_limit,
  input  logic [QUIET_W-1:0] cfg_quiet_len,
  input  logic [HOLD_W-1:0]  cfg_hold_us,
  output logic               irq_pulse,
  output logic               throttle_req
);
  logic               inv_pol_q;
  logic               irq_en_q;
  logic [CNT_W-1:0]   limit_q;
  logic [QUIET_W-1:0] quiet_q;
  logic [HOLD_W-1:0]  hold_q;

  oca_edge_t          edg;
  logic               act_now;
  logic [CNT_W-1:0]   event_cnt;
  logic [HOLD_W-1:0]  hold_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_pol_q <= 1'b0;
      irq_en_q  <= 1'b0;
      limit_q   <= '0;
      quiet_q   <= '0;
      hold_q    <= '0;
    end else if (cfg_we) begin
      inv_pol_q <= cfg_inv_pol;
      irq_en_q  <= cfg_irq_en;
      limit_q   <= cfg_count_limit;
      quiet_q   <= cfg_quiet_len;
      hold_q    <= cfg_hold_us;
    end
  end

  oca_alarm_front #(.SYNC_STAGES(2)) u_front (
    .clk          (clk),
    .rst          (rst),
    .alarm_in     (alarm_in),
    .inv_pol      (inv_pol_q),
    .cfg_we       (cfg_we),
    .inv_pol_next (cfg_inv_pol),
    .edg          (edg)
  );

  assign act_now = edg.act;

  oca_event_counter #(.CNT_W(CNT_W), .QUIET_W(QUIET_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (cfg_we),
    .rise      (edg.rise),
    .irq_en    (irq_en_q),
    .limit     (limit_q),
    .quiet_len (quiet_q),
    .count_q   (event_cnt),
    .irq_q     (irq_pulse)
  );

  oca_hold_stretch #(.HOLD_W(HOLD_W), .US_DIV(US_DIV)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .clr        (cfg_we),
    .act        (edg.act),
    .fall       (edg.fall),
    .hold_us    (hold_q),
    .hold_left  (hold_left),
    .throttle_q (throttle_req)
  );
endmodule

// File: rtl/oca_throttle_chk.sv
module oca_throttle_chk #(
  parameter int CNT_W  = 8,
  parameter int HOLD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              irq_pulse,
  input logic              throttle_req,
  input logic              act_now,
  input logic              irq_en_q,
  input logic [CNT_W-1:0]  limit_q,
  input logic [CNT_W-1:0]  event_cnt,
  input logic [HOLD_W-1:0] hold_left,
  input logic [HOLD_W-1:0] hold_q
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);                                           // R4
  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (event_cnt < limit_q) || (event_cnt == '0));                         // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_en_q);                                             // R6
  AST_THROT_WHILE_ACT: assert property (@(posedge clk) disable iff (rst)
    act_now |=> throttle_req);                                           // R8
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    hold_left <= hold_q);                                                // R9
  AST_HOLD_CANCEL: assert property (@(posedge clk) disable iff (rst)
    act_now |=> (hold_left == '0));                                      // R10
  AST_WE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (event_cnt == '0 && hold_left == '0 && !irq_pulse));      // R11
endmodule

bind oca_throttle oca_throttle_chk #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .irq_pulse    (irq_pulse),
  .throttle_req (throttle_req),
  .act_now      (act_now),
  .irq_en_q     (irq_en_q),
  .limit_q      (limit_q),
  .event_cnt    (event_cnt),
  .hold_left    (hold_left),
  .hold_q       (hold_q)
);

// File: tb/tb_oca_throttle.sv
module tb_oca_throttle;
  localparam int CLK_P   = 10;
  localparam int CNT_W   = 8;
  localparam int QUIET_W = 24;
  localparam int HOLD_W  = 16;
  localparam int US_DIV  = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alarm_in = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_inv_pol = 1'b0;
  logic cfg_irq_en = 1'b0;
  logic [CNT_W-1:0]   cfg_count_limit = '0;
  logic [QUIET_W-1:0] cfg_quiet_len = '0;
  logic [HOLD_W-1:0]  cfg_hold_us = '0;
  logic irq_pulse, throttle_req;

  int n_chk = 0, n_fail = 0, irq_seen = 0;
  logic pol_cur = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  oca_throttle #(.CNT_W(CNT_W), .QUIET_W(QUIET_W), .HOLD_W(HOLD_W), .US_DIV(US_DIV)) dut (
    .clk(clk), .rst(rst), .alarm_in(alarm_in), .cfg_we(cfg_we),
    .cfg_inv_pol(cfg_inv_pol), .cfg_irq_en(cfg_irq_en),
    .cfg_count_limit(cfg_count_limit), .cfg_quiet_len(cfg_quiet_len),
    .cfg_hold_us(cfg_hold_us), .irq_pulse(irq_pulse), .throttle_req(throttle_req));

  always @(negedge clk) if (!rst && irq_pulse) irq_seen++;

  task automatic chk(string req, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_cfg(logic pol, logic en, int lim, int quiet, int hold);
    cfg_inv_pol = pol; cfg_irq_en = en;
    cfg_count_limit = CNT_W'(lim); cfg_quiet_len = QUIET_W'(quiet);
    cfg_hold_us = HOLD_W'(hold);
    cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
    pol_cur = pol;
  endtask

  // one alarm event: active 3 cycles, inactive 3 cycles
  task automatic fire(int n);
    for (int i = 0; i < n; i++) begin
      alarm_in = ~pol_cur; step(3);
      alarm_in = pol_cur;  step(3);
    end
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", irq_pulse, 0);
    chk("R1 throttle after reset", throttle_req, 0);
    fire(3);
    chk("R1 default irq disabled", irq_seen, 0);
    // R9 with default hold 0, R3 latency, R8 while active
    alarm_in = 1'b1; step(2);
    chk("R3 throttle not yet", throttle_req, 0);
    step(1);
    chk("R3 throttle after third edge", throttle_req, 1);
    step(50);
    chk("R8 throttle held while active", throttle_req, 1);
    alarm_in = 1'b0; step(2);
    chk("R9 hold 0 still high", throttle_req, 1);
    step(1);
    chk("R9 hold 0 dropped", throttle_req, 0);
    step(5);
  endtask

  task automatic t_threshold;
    int base;
    do_cfg(1'b0, 1'b1, 3, 0, 0);
    base = irq_seen;
    fire(2);
    chk("R4 no irq before limit", irq_seen, base);
    alarm_in = 1'b1; step(2);
    chk("R4 irq not early", irq_pulse, 0);
    step(1);
    chk("R4 irq on third event", irq_pulse, 1);
    step(1);
    chk("R4 irq single cycle", irq_pulse, 0);
    alarm_in = 1'b0; step(3);
    fire(3);
    chk("R4 rearmed after firing", irq_seen, base + 2);
  endtask

  task automatic t_zero_and_disabled;
    int base;
    do_cfg(1'b0, 1'b1, 0, 0, 0);
    base = irq_seen;
    fire(4);
    chk("R5 limit 0 every event", irq_seen, base + 4);
    do_cfg(1'b0, 1'b0, 0, 0, 0);
    fire(3);
    chk("R6 disabled no irq", irq_seen, base + 4);
  endtask

  task automatic t_quiet;
    int base;
    do_cfg(1'b0, 1'b1, 3, 20, 0);
    base = irq_seen;
    fire(2); step(40); fire(2);
    chk("R7 quiet cleared tally", irq_seen, base);
    fire(1);
    chk("R7 count after restart", irq_seen, base + 1);
    do_cfg(1'b0, 1'b1, 3, 0, 0);
    fire(2); step(100); fire(1);
    chk("R7 quiet 0 keeps tally", irq_seen, base + 2);
  endtask

  task automatic t_polarity;
    int base;
    do_cfg(1'b0, 1'b1, 0, 0, 0);
    alarm_in = 1'b1; step(6);
    do_cfg(1'b1, 1'b1, 0, 0, 0);
    base = irq_seen;
    step(3);
    chk("R2 high level inactive when active-low", throttle_req, 0);
    alarm_in = 1'b0; step(2);
    chk("R2 not yet", throttle_req, 0);
    step(1);
    chk("R2 low level throttles", throttle_req, 1);
    chk("R2 low level counts as event", irq_pulse, 1);
    alarm_in = 1'b1; step(4);
    chk("R2 release on high", throttle_req, 0);
    chk("R2 one irq", irq_seen, base + 1);
    do_cfg(1'b0, 1'b0, 0, 0, 0);
    alarm_in = 1'b0; step(10);
  endtask

  task automatic t_hold;
    do_cfg(1'b0, 1'b0, 0, 0, 3);
    alarm_in = 1'b1; step(5);
    alarm_in = 1'b0; step(152);
    chk("R9 held until end", throttle_req, 1);
    step(1);
    chk("R9 dropped after hold", throttle_req, 0);
  endtask

  task automatic t_cancel;
    do_cfg(1'b0, 1'b0, 0, 0, 3);
    alarm_in = 1'b1; step(5);
    alarm_in = 1'b0; step(60);
    chk("R10 within hold", throttle_req, 1);
    alarm_in = 1'b1; step(5);
    chk("R10 realarm keeps throttle", throttle_req, 1);
    alarm_in = 1'b0; step(152);
    chk("R10 full hold restarted", throttle_req, 1);
    step(1);
    chk("R10 dropped after full hold", throttle_req, 0);
  endtask

  task automatic t_cfg_clear;
    int base;
    do_cfg(1'b0, 1'b0, 0, 0, 3);
    alarm_in = 1'b1; step(5);
    alarm_in = 1'b0; step(20);
    chk("R11 hold running", throttle_req, 1);
    do_cfg(1'b0, 1'b0, 0, 0, 3);
    chk("R11 write cancels hold", throttle_req, 0);
    do_cfg(1'b0, 1'b1, 3, 0, 0);
    base = irq_seen;
    fire(2);
    do_cfg(1'b0, 1'b1, 3, 0, 0);
    fire(2);
    chk("R11 write cleared tally", irq_seen, base);
    fire(1);
    chk("R11 count after write", irq_seen, base + 1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset;
    t_threshold;
    t_zero_and_disabled;
    t_quiet;
    t_polarity;
    t_hold;
    t_cancel;
    t_cfg_clear;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule